// File: doc/BRIEF.md
# Dual-Bank ADC Capture Buffer

This block sits between a parallel-output ADC, a design under test and a slow processor. It paces the converter with a conversion-start pulse taken from a programmable divider of the system clock. Each result that the ADC marks valid is forwarded to the design under test at full rate. The forwarding goes either straight through, combinationally, or through a single pipeline register.

Every valid sample is also written into one of two equal capture banks. When the bank being filled is full, it is handed to the processor as a complete section and writing moves to the other bank. The processor reads the handed-over section at its own pace through a synchronous read port and then releases it. If a second section completes before the processor has released the first, the block raises an overrun flag. The newest section becomes the readable one, and the older bank is reused for the next fill.

Top module: `adc_pingpong_capture`

## Requirements
- R1: While `enable_i` is high, `conv_start_o` is a one-cycle pulse that repeats every `div_i`+1 clock cycles. While `enable_i` is low, no pulse is produced.
- R2: With `bypass_i` high, `dut_data_o` and `dut_valid_o` equal `adc_data_i` and `adc_valid_i` in the same cycle.
- R3: With `bypass_i` low, `dut_data_o` and `dut_valid_o` present the ADC inputs delayed by exactly one clock cycle.
- R4: Valid samples are written to consecutive addresses 0 to DEPTH-1 of the active bank. The cycle after the DEPTH-th sample, `ready_o` is 1, `rd_bank_o` names the filled bank (0 or 1), and writing continues in the other bank.
- R5: `rd_data_o` returns the word at `rd_addr_i` of bank `rd_bank_o` one clock cycle after the address is applied.
- R6: The readable section does not change while the other bank is being filled.
- R7: A `release_i` pulse clears `ready_o` and `overrun_o` in the next cycle.
- R8: If a section completes while `ready_o` is 1 and no release is given, `overrun_o` becomes 1, `ready_o` stays 1, `rd_bank_o` switches to the newest section, and the older bank is refilled next.
- R9: After reset, `conv_start_o`, `ready_o` and `overrun_o` are 0, `rd_bank_o` is 1, writing starts in bank 0, and the non-bypass `dut_valid_o` is 0.
- R10: If a section completes in the same cycle as a release, `ready_o` stays 1 and `overrun_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Enables conversion pacing |
| div_i | input | DIV_W | Conversion period minus one, in clock cycles |
| conv_start_o | output | 1 | Conversion-start pulse to the ADC |
| adc_valid_i | input | 1 | ADC result valid |
| adc_data_i | input | DATA_W | ADC result |
| bypass_i | input | 1 | 1: combinational path to the DUT; 0: registered path |
| dut_data_o | output | DATA_W | Sample to the design under test |
| dut_valid_o | output | 1 | Sample valid to the design under test |
| rd_addr_i | input | AW | Processor read address |
| rd_data_o | output | DATA_W | Processor read data, one cycle latency |
| rd_bank_o | output | 1 | Bank holding the readable section |
| ready_o | output | 1 | A completed section is waiting |
| overrun_o | output | 1 | A section completed before the previous one was released |
| release_i | input | 1 | Processor has finished with the ready section |

## Verification
The bench builds the block with DEPTH=8, DATA_W=16 and DIV_W=8. Short sections let it complete four sections in a few dozen cycles. That brings within reach the bank swap, a read during a fill, an overrun that overwrites the oldest bank, and a release that lands in the same cycle as a completion. Small divider values, 3 and 6, show several conversion periods, and the test also checks that pacing stops when it is disabled.

// File: rtl/adc_pingpong_capture.sv
module adc_pingpong_capture #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              conv_start_o,
  input  logic              adc_valid_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              bypass_i,
  output logic [DATA_W-1:0] dut_data_o,
  output logic              dut_valid_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bank_o,
  output logic              ready_o,
  output logic              overrun_o,
  input  logic              release_i
);

  logic [DIV_W-1:0]  div_cnt;
  logic [DATA_W-1:0] pipe_data;
  logic              pipe_valid;
  logic [DATA_W-1:0] bank0 [DEPTH];
  logic [DATA_W-1:0] bank1 [DEPTH];
  logic              wr_bank;
  logic [AW-1:0]     wr_ptr;
  logic              sect_done;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable_i) begin
      div_cnt      <= '0;
      conv_start_o <= 1'b0;
    end else if (div_cnt >= div_i) begin
      div_cnt      <= '0;
      conv_start_o <= 1'b1;
    end else begin
      div_cnt      <= div_cnt + 1'b1;
      conv_start_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_data  <= '0;
      pipe_valid <= 1'b0;
    end else begin
      pipe_data  <= adc_data_i;
      pipe_valid <= adc_valid_i;
    end
  end

  assign dut_data_o  = bypass_i ? adc_data_i  : pipe_data;
  assign dut_valid_o = bypass_i ? adc_valid_i : pipe_valid;

  assign sect_done = adc_valid_i && (wr_ptr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (adc_valid_i) begin
      if (wr_bank) bank1[wr_ptr] <= adc_data_i;
      else         bank0[wr_ptr] <= adc_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      wr_ptr    <= '0;
      rd_bank_o <= 1'b1;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (adc_valid_i)
        wr_ptr <= sect_done ? '0 : wr_ptr + 1'b1;
      if (sect_done) begin
        wr_bank   <= ~wr_bank;
        rd_bank_o <= wr_bank;
        ready_o   <= 1'b1;
        overrun_o <= (overrun_o || ready_o) && !release_i;
      end else if (release_i) begin
        ready_o   <= 1'b0;
        overrun_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    rd_data_o <= rd_bank_o ? bank1[rd_addr_i] : bank0[rd_addr_i];

  a_r1_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_o && div_i != '0 && $stable(div_i)) |=> !conv_start_o);

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !conv_start_o);

  a_r3_one_cycle_delay: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_i |=> (!bypass_i -> dut_valid_o == $past(adc_valid_i)));

  a_r4_ready_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    sect_done |=> ready_o);

  a_r4_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    sect_done |=> (wr_bank != $past(wr_bank)) && (rd_bank_o == $past(wr_bank)));

  a_r6_banks_differ: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (wr_bank != rd_bank_o));

  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !sect_done) |=> (!ready_o && !overrun_o));

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_done && ready_o && !release_i) |=> overrun_o);

  a_r10_release_race: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_done && release_i) |=> (ready_o && !overrun_o));

endmodule

// File: tb/adc_pingpong_capture_bench.sv
module adc_pingpong_capture_bench;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int DIV_W  = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [DATA_W-1:0] VEC [DEPTH] = '{
    16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'hA5A5, 16'h5A5A, 16'h0001, 16'h1234};

  logic clk = 0, rst_n = 0, enable_i = 0, adc_valid_i = 0, bypass_i = 0, release_i = 0;
  logic [DIV_W-1:0] div_i = '0;
  logic [DATA_W-1:0] adc_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic conv_start_o, dut_valid_o, rd_bank_o, ready_o, overrun_o;
  logic [DATA_W-1:0] dut_data_o, rd_data_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  adc_pingpong_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_adc_pingpong_capture (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .div_i(div_i), .conv_start_o(conv_start_o),
    .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i), .bypass_i(bypass_i),
    .dut_data_o(dut_data_o), .dut_valid_o(dut_valid_o), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .rd_bank_o(rd_bank_o), .ready_o(ready_o),
    .overrun_o(overrun_o), .release_i(release_i));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input logic byp, input logic rel);
    @(negedge clk);
    adc_valid_i = 1; adc_data_i = d; bypass_i = byp; release_i = rel;
    #1;
    if (byp) begin
      chk("R2 bypass data", dut_data_o, d);
      chk("R2 bypass valid", dut_valid_o, 1);
    end else chk("R3 valid not yet", dut_valid_o, 0);
    @(negedge clk);
    adc_valid_i = 0; release_i = 0;
    if (!byp) begin
      chk("R3 delayed data", dut_data_o, d);
      chk("R3 delayed valid", dut_valid_o, 1);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk); rd_addr_i = a;
    @(negedge clk); v = rd_data_o;
  endtask

  task automatic measure(input logic [DIV_W-1:0] d);
    int last, gaps;
    last = -1; gaps = 0;
    @(negedge clk); div_i = d; enable_i = 1;
    for (int c = 0; c < 8 * (d + 1) + 4; c++) begin
      @(negedge clk);
      if (conv_start_o) begin
        if (last >= 0) begin chk("R1 pulse period", c - last, d + 1); gaps++; end
        last = c;
      end
    end
    chk("R1 pulses seen", gaps >= 3, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    int quiet;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 conv_start", conv_start_o, 0);
    chk("R9 ready", ready_o, 0);
    chk("R9 overrun", overrun_o, 0);
    chk("R9 rd_bank", rd_bank_o, 1);
    chk("R9 dut_valid", dut_valid_o, 0);

    measure(8'd3);
    measure(8'd6);
    @(negedge clk); enable_i = 0;
    @(negedge clk);
    quiet = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); quiet += conv_start_o; end
    chk("R1 disabled no pulse", quiet, 0);

    for (int i = 0; i < DEPTH; i++) begin
      send(VEC[i], 1'b1, 1'b0);
      if (i < DEPTH - 1) chk("R4 not ready early", ready_o, 0);
    end
    chk("R4 ready after fill", ready_o, 1);
    chk("R4 filled bank 0", rd_bank_o, 0);
    chk("R4 no overrun", overrun_o, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v); chk("R5 read bank0", v, VEC[i]);
    end

    for (int i = 0; i < DEPTH; i++) begin
      send(16'h2000 + 16'(i), 1'b0, 1'b0);
      if (i == 3) begin
        rd(AW'(2), v); chk("R6 stable during fill", v, VEC[2]);
        chk("R6 bank held", rd_bank_o, 0);
      end
    end
    chk("R8 overrun set", overrun_o, 1);
    chk("R8 ready held", ready_o, 1);
    chk("R8 newest bank", rd_bank_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v); chk("R8 newest data", v, 16'h2000 + 16'(i));
    end

    @(negedge clk); release_i = 1;
    @(negedge clk); release_i = 0;
    chk("R7 ready cleared", ready_o, 0);
    chk("R7 overrun cleared", overrun_o, 0);

    for (int i = 0; i < DEPTH; i++) send(16'h3000 + 16'(i), 1'b1, 1'b0);
    chk("R8 older bank refilled", rd_bank_o, 0);
    rd(AW'(5), v); chk("R8 refilled data", v, 16'h3005);

    for (int i = 0; i < DEPTH; i++) send(16'h4000 + 16'(i), 1'b0, i == DEPTH - 1);
    chk("R10 ready kept", ready_o, 1);
    chk("R10 no overrun", overrun_o, 0);
    chk("R10 bank", rd_bank_o, 1);
    rd(AW'(7), v); chk("R10 data", v, 16'h4007);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule